// File: doc/BRIEF.md
# Multi-UART Interrupt Aggregator and Register Decoder

This block sits between a 32-bit memory-mapped request port and a bank of up to sixteen 16550-style UART cores. It splits a 16 KiB address space into two areas. The low 4 KiB hold a handful of global registers: a fixed identification word, the channel count, a per-channel interrupt status word, and two 32-bit masks (interrupt enable and wake enable). Each mask is written through a pair of addresses, one that sets bits and one that clears bits. From offset 0x1000 upward, equal 0x200-byte windows map one window to each channel. The lower half of each window is forwarded to the selected UART through a simple register port. The upper half is a reserved DMA area that reads as zero.

The per-channel interrupt request levels are registered into the status word. The block drives one level-sensitive interrupt output, which is high while any status bit with its enable bit set is high. The UART cores themselves are outside the block and are reached only through the register port.

Top module: `muart_agg`

## Requirements
- R1: A read of offset 0x00 returns 0x00070002. A read of offset 0x04 returns the channel-count parameter NCH, which lies in the range 1..16.
- R2: Read data appears on `rsp_rdata` one clock after the read request and holds until the next read.
- R3: A write to offset 0x0C ORs the write data into the 32-bit interrupt enable mask. A read of 0x0C returns the mask.
- R4: A write to offset 0x10 clears each enable-mask bit that is 1 in the write data. A read of 0x10 returns the bitwise inverse of the whole 32-bit mask.
- R5: Offsets 0x14 (set) and 0x18 (clear, reads inverted) act the same way on a separate wake mask. The wake mask never affects `irq_out`.
- R6: Status bit i (read at 0x08, zero-extended) equals `uart_irq[i]` as sampled at the previous clock edge.
- R7: `irq_out` is high exactly when status AND the low NCH bits of the enable mask is nonzero. It follows a mask write or a status change with no further delay.
- R8: For an address of 0x1000 or above, the channel is (addr-0x1000)/0x200 and the local offset is addr mod 0x200. When the channel is below NCH and the local offset is below 0x100, exactly `uart_sel[channel]` is high in the request cycle. `uart_addr` carries the local offset, `uart_wr` carries the write flag and `uart_wdata` carries the data. A read returns `uart_rdata` as sampled in that cycle.
- R9: Local offsets 0x100..0x1FF in a channel window read zero, select no channel and raise no write strobe.
- R10: A channel index at or above NCH reads zero and strobes nothing. An unmapped global offset below 0x1000 reads zero.
- R11: Writes to 0x00, 0x04 and 0x08 change no register value.
- R12: Synchronous reset clears the status word, the enable mask and the wake mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one clock after the request |
| uart_sel | output | NCH | One-hot channel select |
| uart_addr | output | 8 | Local register offset within the channel |
| uart_wr | output | 1 | Write strobe to the selected channel |
| uart_wdata | output | 32 | Write data to the channel |
| uart_rdata | input | 32 | Read data from the selected channel (combinational) |
| uart_irq | input | NCH | Per-channel interrupt request levels |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
The assertions assume that the request inputs are stable and free of X whenever `req_valid` is high. They also assume that `uart_irq` is a plain level that changes only between clock edges. The bench drives every input on the falling edge and returns UART read data combinationally from the one-hot select, so both assumptions hold for all stimulus. The bench samples all results on the next falling edge, so a registered response is observed one full cycle after its request.

// File: rtl/muart_pkg.sv
package muart_pkg;
    localparam int unsigned ADDR_W   = 14;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LOC_W    = 9;   // window is 0x200 bytes
    localparam int unsigned UADDR_W  = 8;   // forwarded part, below 0x100
    localparam int unsigned IDX_W    = ADDR_W - LOC_W;
    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0007_0002;

    localparam logic [11:0] OFS_IDENT  = 12'h000;
    localparam logic [11:0] OFS_COUNT  = 12'h004;
    localparam logic [11:0] OFS_STAT   = 12'h008;
    localparam logic [11:0] OFS_EN_SET = 12'h00C;
    localparam logic [11:0] OFS_EN_CLR = 12'h010;
    localparam logic [11:0] OFS_WK_SET = 12'h014;
    localparam logic [11:0] OFS_WK_CLR = 12'h018;

    typedef enum logic [1:0] {
        K_NULL   = 2'd0,
        K_GLOBAL = 2'd1,
        K_UART   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [11:0]        gofs;
        logic [IDX_W-1:0]   idx;
        logic [UADDR_W-1:0] loc;
    } dec_t;
endpackage

// File: rtl/muart_decode.sv
module muart_decode
    import muart_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [IDX_W-1:0] WIN_BASE_IDX = IDX_W'(8); // 0x1000 / 0x200

    logic [IDX_W-1:0] idx;
    logic             in_win;

    always_comb begin
        in_win = (addr[ADDR_W-1:12] != '0);
        idx    = addr[ADDR_W-1:LOC_W] - WIN_BASE_IDX;
        dec.gofs = addr[11:0];
        dec.idx  = idx;
        dec.loc  = addr[UADDR_W-1:0];
        if (!in_win)
            dec.kind = K_GLOBAL;
        else if (addr[UADDR_W] == 1'b0 && idx < IDX_W'(NCH))
            dec.kind = K_UART;
        else
            dec.kind = K_NULL;
    end
endmodule

// File: rtl/muart_mask.sv
module muart_mask
    import muart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (set_we)
            mask <= mask | wdata;
        else if (clr_we)
            mask <= mask & ~wdata;
    end
endmodule

// File: rtl/muart_irq.sv
module muart_irq #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_lvl,
    input  logic [NCH-1:0] enable,
    output logic [NCH-1:0] status,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= req_lvl;
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/muart_agg.sv
module muart_agg
    import muart_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [NCH-1:0]      uart_sel,
    output logic [UADDR_W-1:0]  uart_addr,
    output logic                uart_wr,
    output logic [DATA_W-1:0]   uart_wdata,
    input  logic [DATA_W-1:0]   uart_rdata,
    input  logic [NCH-1:0]      uart_irq,
    output logic                irq_out
);
    dec_t              dec;
    logic              glb_wr;
    logic [DATA_W-1:0] irq_en;
    logic [DATA_W-1:0] wake_en;
    logic [NCH-1:0]    stat;
    logic [DATA_W-1:0] rd_next;

    muart_decode #(.NCH(NCH)) u_dec (.addr(req_addr), .dec(dec));

    assign glb_wr = req_valid && req_write && dec.kind == K_GLOBAL;

    muart_mask u_en (
        .clk(clk), .rst(rst),
        .set_we(glb_wr && dec.gofs == OFS_EN_SET),
        .clr_we(glb_wr && dec.gofs == OFS_EN_CLR),
        .wdata(req_wdata), .mask(irq_en)
    );

    muart_mask u_wake (
        .clk(clk), .rst(rst),
        .set_we(glb_wr && dec.gofs == OFS_WK_SET),
        .clr_we(glb_wr && dec.gofs == OFS_WK_CLR),
        .wdata(req_wdata), .mask(wake_en)
    );

    muart_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst(rst),
        .req_lvl(uart_irq), .enable(irq_en[NCH-1:0]),
        .status(stat), .irq(irq_out)
    );

    // Channel strobes: one select line per populated channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_sel
        assign uart_sel[ch] = req_valid && dec.kind == K_UART
                              && dec.idx == IDX_W'(ch);
    end
    assign uart_wr    = req_valid && req_write && dec.kind == K_UART;
    assign uart_addr  = dec.loc;
    assign uart_wdata = req_wdata;

    always_comb begin
        rd_next = '0;
        if (dec.kind == K_UART) begin
            rd_next = uart_rdata;
        end else if (dec.kind == K_GLOBAL) begin
            case (dec.gofs)
                OFS_IDENT:  rd_next = IDENT_WORD;
                OFS_COUNT:  rd_next = DATA_W'(NCH);
                OFS_STAT:   rd_next = DATA_W'(stat);
                OFS_EN_SET: rd_next = irq_en;
                OFS_EN_CLR: rd_next = ~irq_en;
                OFS_WK_SET: rd_next = wake_en;
                OFS_WK_CLR: rd_next = ~wake_en;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_rdata <= '0;
        else if (req_valid && !req_write)
            rsp_rdata <= rd_next;
    end
endmodule

// File: rtl/muart_agg_chk.sv
module muart_agg_chk
    import muart_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [NCH-1:0]    uart_sel,
    input logic              uart_wr,
    input logic [NCH-1:0]    uart_irq,
    input logic              irq_out,
    input logic [DATA_W-1:0] en_q,
    input logic [NCH-1:0]    stat_q
);
    p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 14'h000C)
        |=> ((en_q & $past(req_wdata)) == $past(req_wdata)));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 14'h0010)
        |=> ((en_q & $past(req_wdata)) == '0));

    p_stat_follow_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stat_q == $past(uart_irq));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q[NCH-1:0] == '0) |-> !irq_out);

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(uart_sel));

    p_wr_needs_sel_r8: assert property (@(posedge clk) disable iff (rst)
        uart_wr |-> ($countones(uart_sel) == 1 && req_write));

    p_dma_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[ADDR_W-1:12] != '0 && req_addr[8])
        |-> (uart_sel == '0 && !uart_wr));

    p_global_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[ADDR_W-1:12] == '0) |-> uart_sel == '0);
endmodule

bind muart_agg muart_agg_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .uart_sel(uart_sel), .uart_wr(uart_wr),
    .uart_irq(uart_irq), .irq_out(irq_out),
    .en_q(irq_en), .stat_q(stat)
);

// File: tb/sim_muart_agg.sv
module sim_muart_agg;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [13:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rsp_rdata;
    logic [NCH-1:0] uart_sel;
    logic [7:0]  uart_addr;
    logic        uart_wr;
    logic [31:0] uart_wdata;
    logic [31:0] uart_rdata;
    logic [NCH-1:0] uart_irq;
    logic        irq_out;

    int ntests = 0;
    int nfail  = 0;

    // sampled during the request cycle / after it
    logic [NCH-1:0] s_sel;
    logic           s_wr;
    logic [7:0]     s_addr;
    logic [31:0]    s_wdata;
    logic [31:0]    s_rd;

    always #4 clk = ~clk;

    muart_agg #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata),
        .uart_sel(uart_sel), .uart_addr(uart_addr),
        .uart_wr(uart_wr), .uart_wdata(uart_wdata),
        .uart_rdata(uart_rdata),
        .uart_irq(uart_irq), .irq_out(irq_out)
    );

    function automatic logic [31:0] stub_val(input int ch, input logic [7:0] a);
        return {8'hC0 + 8'(ch), 8'h00, a, 8'h5A};
    endfunction

    // UART stub: combinational read data from the one-hot select
    always_comb begin
        uart_rdata = 32'hDEAD_BEEF;
        for (int i = 0; i < NCH; i++)
            if (uart_sel[i]) uart_rdata = stub_val(i, uart_addr);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        s_sel = uart_sel; s_wr = uart_wr; s_addr = uart_addr; s_wdata = uart_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_rd = rsp_rdata;
    endtask

    task automatic t_reset_state;
        acc(1'b0, 14'h0008, '0); check("R12 status after reset", s_rd, 32'h0);
        acc(1'b0, 14'h000C, '0); check("R12 enable after reset", s_rd, 32'h0);
        acc(1'b0, 14'h0014, '0); check("R12 wake after reset", s_rd, 32'h0);
        check("R7 irq low after reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_ident;
        acc(1'b0, 14'h0000, '0); check("R1 ident", s_rd, 32'h0007_0002);
        acc(1'b0, 14'h0004, '0); check("R1 count", s_rd, 32'(NCH));
        // R2: held until the next read, unaffected by a write
        acc(1'b1, 14'h0014, 32'h0); check("R2 hold across write", rsp_rdata, 32'(NCH));
        acc(1'b1, 14'h0018, 32'h0);
    endtask

    task automatic t_enable;
        acc(1'b1, 14'h000C, 32'h0000_0011);
        acc(1'b1, 14'h000C, 32'h8000_0002);
        acc(1'b0, 14'h000C, '0); check("R3 set ORs", s_rd, 32'h8000_0013);
        acc(1'b1, 14'h0010, 32'h8000_0001);
        acc(1'b0, 14'h000C, '0); check("R4 clear", s_rd, 32'h0000_0012);
        acc(1'b0, 14'h0010, '0); check("R4 inverse read", s_rd, 32'hFFFF_FFED);
        acc(1'b1, 14'h0010, 32'hFFFF_FFFF);
    endtask

    task automatic t_status_irq;
        @(negedge clk); uart_irq = 6'b100101;
        @(negedge clk);
        acc(1'b0, 14'h0008, '0); check("R6 status follows", s_rd, 32'h25);
        check("R7 irq masked", 32'(irq_out), 32'h0);
        acc(1'b1, 14'h000C, 32'h0000_0004);
        check("R7 irq on enable", 32'(irq_out), 32'h1);
        @(negedge clk); uart_irq = 6'b100001;
        @(negedge clk);
        check("R7 irq drops with status", 32'(irq_out), 32'h0);
        acc(1'b0, 14'h0008, '0); check("R6 status cleared bit", s_rd, 32'h21);
        acc(1'b1, 14'h000C, 32'h0000_0020);
        check("R7 irq other channel", 32'(irq_out), 32'h1);
        acc(1'b1, 14'h0010, 32'hFFFF_FFFF);
        check("R7 irq off after clear", 32'(irq_out), 32'h0);
    endtask

    task automatic t_wake;
        acc(1'b1, 14'h0014, 32'h0000_0021);
        check("R5 wake no irq", 32'(irq_out), 32'h0);
        acc(1'b0, 14'h0014, '0); check("R5 wake set", s_rd, 32'h21);
        acc(1'b1, 14'h0018, 32'h0000_0001);
        acc(1'b0, 14'h0018, '0); check("R5 wake inverse", s_rd, 32'hFFFF_FFDF);
        acc(1'b0, 14'h000C, '0); check("R5 enable untouched", s_rd, 32'h0);
    endtask

    task automatic t_channels;
        for (int ch = 0; ch < NCH; ch++) begin
            logic [13:0] a;
            a = 14'h1000 + 14'(ch) * 14'h200 + 14'h0014;
            acc(1'b1, a, 32'hA5A5_0000 + 32'(ch));
            check("R8 write sel", 32'(s_sel), 32'(1 << ch));
            check("R8 write strobe", 32'(s_wr), 32'h1);
            check("R8 local addr", 32'(s_addr), 32'h14);
            check("R8 write data", s_wdata, 32'hA5A5_0000 + 32'(ch));
            acc(1'b0, a + 14'h00EB, '0);
            check("R8 read data", s_rd, stub_val(ch, 8'hFF));
            check("R8 read no strobe", 32'(s_wr), 32'h0);
        end
    endtask

    task automatic t_dma;
        acc(1'b1, 14'h1000 + 14'h200 + 14'h100, 32'h1234_5678);
        check("R9 dma write no sel", 32'(s_sel), 32'h0);
        check("R9 dma write no strobe", 32'(s_wr), 32'h0);
        acc(1'b0, 14'h1000 + 14'h1FC, '0);
        check("R9 dma read zero", s_rd, 32'h0);
    endtask

    task automatic t_unpop;
        acc(1'b1, 14'h1000 + 14'(NCH) * 14'h200, 32'hFFFF_FFFF);
        check("R10 unpopulated write", 32'(s_sel) | 32'(s_wr), 32'h0);
        acc(1'b0, 14'h1000 + 14'(NCH) * 14'h200 + 14'h4, '0);
        check("R10 unpopulated read", s_rd, 32'h0);
        acc(1'b0, 14'h3FFC, '0); check("R10 top of space", s_rd, 32'h0);
        acc(1'b0, 14'h001C, '0); check("R10 unmapped global", s_rd, 32'h0);
        acc(1'b0, 14'h0FFC, '0); check("R10 unmapped global high", s_rd, 32'h0);
    endtask

    task automatic t_readonly;
        acc(1'b1, 14'h0000, 32'hFFFF_FFFF);
        acc(1'b1, 14'h0004, 32'hFFFF_FFFF);
        acc(1'b1, 14'h0008, 32'hFFFF_FFFF);
        acc(1'b0, 14'h0000, '0); check("R11 ident ro", s_rd, 32'h0007_0002);
        acc(1'b0, 14'h0004, '0); check("R11 count ro", s_rd, 32'(NCH));
        acc(1'b0, 14'h0008, '0); check("R11 status ro", s_rd, 32'h21);
        acc(1'b0, 14'h000C, '0); check("R11 enable untouched", s_rd, 32'h0);
    endtask

    task automatic t_reset_clear;
        acc(1'b1, 14'h000C, 32'h0000_003F);
        acc(1'b1, 14'h0014, 32'h0000_00FF);
        @(negedge clk); rst = 1'b1; uart_irq = '0;
        @(negedge clk); rst = 1'b0;
        check("R12 irq low in reset", 32'(irq_out), 32'h0);
        acc(1'b0, 14'h000C, '0); check("R12 enable cleared", s_rd, 32'h0);
        acc(1'b0, 14'h0014, '0); check("R12 wake cleared", s_rd, 32'h0);
        acc(1'b0, 14'h0008, '0); check("R12 status cleared", s_rd, 32'h0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; uart_irq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_ident();
        t_enable();
        t_status_irq();
        t_wake();
        t_channels();
        t_dma();
        t_unpop();
        t_readonly();
        t_reset_clear();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule